// File: doc/BRIEF.md
# SPI Flash Status Register Responder

This block holds the three-byte status register of an emulated serial flash device and lives entirely in the SPI clock domain. A command parser ahead of it hands over each received opcode as a one-cycle strobe. When the opcode matches one of three configurable read-status opcodes, the block shifts the corresponding status byte out on the serial data output, most significant bit first. It keeps repeating that byte until chip select goes high. The write-enable and write-disable opcodes set and clear the write-enable latch. A strobe from the upload path sets the BUSY flag.

The register exists in two copies. Software updates arrive already popped from a clock-crossing FIFO and overwrite a staged copy. Hardware changes to the write-enable latch and BUSY also go to the staged copy. The committed copy is the only one the host reads back and the only one software sees. It takes the staged value in the clock cycle in which chip select is first seen high after being low. A read in progress therefore always returns one consistent value, and every update pending at the end of a transaction becomes visible at once. Chip select never clears the register.

Top module: `spi_status_responder`

## Requirements
- R1: After reset the committed status reads 24'h000000 and `sdo` is 0.
- R2: A software write (`sw_wr` high, value on `sw_wdata`) changes only the staged copy. `status_q` takes the staged value in the cycle after the first clock edge that samples `csb` high following an edge that sampled it low. It does not change at any other time.
- R3: Read-status opcode k is `cfg_rd_op[8k+7:8k]`, for k = 0, 1, 2. When it is accepted (`op_valid` with `csb` low), `sdo` carries bit 7 of `status_q[8k+7:8k]` in the cycle after that edge, and then bits 6 down to 0 on the following cycles. The byte repeats for as long as `csb` stays low.
- R4: An accepted opcode equal to `cfg_wren_op` sets the write-enable latch, which is status bit 1, in the staged copy.
- R5: An accepted opcode equal to `cfg_wrdi_op` clears status bit 1 in the staged copy. When the two configured opcodes are equal, the write-enable action takes priority.
- R6: A `busy_set` pulse sets BUSY, which is status bit 0, in the staged copy. BUSY is cleared only by a software write that has bit 0 at 0.
- R7: When a software write and a hardware update of bit 0 or bit 1 fall in the same cycle, the hardware update decides that bit and the software value decides every other bit.
- R8: An accepted opcode that matches no read, write-enable or write-disable opcode leaves `sdo` at 0 and leaves the status unchanged.
- R9: `sdo` is 0 from the first edge that samples `csb` high. An `op_valid` strobe while `csb` is high is ignored.
- R10: `status_q` stays stable while `csb` is low, even when software writes arrive during a read. A read in progress keeps shifting the value that was committed before it started.
- R11: When several read opcodes are equal, the lowest index wins, so an opcode configured at index 0 returns byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SPI-domain clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csb | input | 1 | Chip select, active low |
| op_valid | input | 1 | One-cycle strobe: opcode byte received |
| op_code | input | 8 | Received opcode |
| busy_set | input | 1 | An uploaded command requests BUSY |
| sw_wr | input | 1 | Software update strobe (already past the clock-crossing FIFO) |
| sw_wdata | input | 24 | Software status value |
| cfg_rd_op | input | 24 | Three read-status opcodes, index k at [8k+7:8k] |
| cfg_wren_op | input | 8 | Write-enable opcode |
| cfg_wrdi_op | input | 8 | Write-disable opcode |
| sdo | output | 1 | Serial data output |
| status_q | output | 24 | Committed status value |

## Verification
A wrong staged copy stays hidden until the next chip-select release. It then appears on `status_q` one cycle after the releasing edge, and on `sdo` during the next read-status transaction. A wrong byte select or bit counter shows on `sdo` within the first eight cycles after the opcode strobe. The repeated pass exposes a bad wrap from bit 0 back to bit 7. A commit at the wrong moment shows as `status_q` moving while `csb` is still low.

// File: rtl/spi_status_responder.sv
module spi_status_responder #(
  parameter int OPW      = 8,
  parameter int BYTE_W   = 8,
  parameter int NBYTES   = 3,
  parameter int BUSY_BIT = 0,
  parameter int WEL_BIT  = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     csb,
  input  logic                     op_valid,
  input  logic [OPW-1:0]           op_code,
  input  logic                     busy_set,
  input  logic                     sw_wr,
  input  logic [BYTE_W*NBYTES-1:0] sw_wdata,
  input  logic [OPW*NBYTES-1:0]    cfg_rd_op,
  input  logic [OPW-1:0]           cfg_wren_op,
  input  logic [OPW-1:0]           cfg_wrdi_op,
  output logic                     sdo,
  output logic [BYTE_W*NBYTES-1:0] status_q
);
  localparam int SW   = BYTE_W * NBYTES;
  localparam int SELW = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam int CW   = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

  logic [SW-1:0]     stg, stg_nx;
  logic              csb_q, active, hit;
  logic [SELW-1:0]   sel, hit_idx;
  logic [CW-1:0]     cnt;
  logic [BYTE_W-1:0] cbyte [NBYTES];

  wire op_ok  = op_valid & ~csb;
  wire wren   = op_ok & (op_code == cfg_wren_op);
  wire wrdi   = op_ok & (op_code == cfg_wrdi_op) & ~wren;
  wire commit = csb & ~csb_q;

  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    for (int k = NBYTES - 1; k >= 0; k--)
      if (cfg_rd_op[k*OPW +: OPW] == op_code) begin
        hit = 1'b1;
        hit_idx = SELW'(k);
      end
  end

  always_comb begin
    stg_nx = sw_wr ? sw_wdata : stg;
    if (wren) stg_nx[WEL_BIT] = 1'b1;
    else if (wrdi) stg_nx[WEL_BIT] = 1'b0;
    if (busy_set) stg_nx[BUSY_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stg      <= '0;
      status_q <= '0;
      csb_q    <= 1'b1;
    end else begin
      stg   <= stg_nx;
      csb_q <= csb;
      if (commit) status_q <= stg;
    end

  // bit counter wraps from 0 to BYTE_W-1 (BYTE_W a power of two)
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active <= 1'b0;
      sel    <= '0;
      cnt    <= '0;
    end else if (csb) begin
      active <= 1'b0;
    end else if (op_ok && hit) begin
      active <= 1'b1;
      sel    <= hit_idx;
      cnt    <= CW'(BYTE_W - 1);
    end else if (active) begin
      cnt <= cnt - 1'b1;
    end

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    assign cbyte[g] = status_q[g*BYTE_W +: BYTE_W];
  end

  assign sdo = active & cbyte[sel][cnt];
endmodule

// File: rtl/spi_status_responder_chk.sv
module spi_status_responder_chk #(
  parameter int OPW = 8,
  parameter int SW = 24,
  parameter int BUSY_BIT = 0,
  parameter int WEL_BIT = 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           csb,
  input logic           op_valid,
  input logic [OPW-1:0] op_code,
  input logic           busy_set,
  input logic [OPW-1:0] cfg_wren_op,
  input logic [OPW-1:0] cfg_wrdi_op,
  input logic           sdo,
  input logic [SW-1:0]  status_q,
  input logic [SW-1:0]  stg
);
  AST_STABLE_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !csb |=> $stable(status_q)); // R10

  AST_COMMIT_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (csb && !$past(csb)) |=> (status_q == $past(stg))); // R2

  AST_WREN_SETS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !csb && op_code == cfg_wren_op) |=> stg[WEL_BIT]); // R4

  AST_WRDI_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !csb && op_code == cfg_wrdi_op && op_code != cfg_wren_op) |=> !stg[WEL_BIT]); // R5

  AST_BUSY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_set |=> stg[BUSY_BIT]); // R6

  AST_SDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (csb && $past(csb)) |-> !sdo); // R9
endmodule

bind spi_status_responder spi_status_responder_chk #(
  .OPW(OPW), .SW(BYTE_W*NBYTES), .BUSY_BIT(BUSY_BIT), .WEL_BIT(WEL_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .csb(csb), .op_valid(op_valid), .op_code(op_code),
  .busy_set(busy_set), .cfg_wren_op(cfg_wren_op), .cfg_wrdi_op(cfg_wrdi_op),
  .sdo(sdo), .status_q(status_q), .stg(stg)
);

// File: tb/spi_status_responder_test.sv
module spi_status_responder_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, csb = 1'b1, op_valid = 1'b0, busy_set = 1'b0, sw_wr = 1'b0;
  logic [7:0]  op_code = '0, cfg_wren_op = 8'h06, cfg_wrdi_op = 8'h04;
  logic [23:0] sw_wdata = '0, cfg_rd_op = {8'h15, 8'h35, 8'h05};
  logic        sdo;
  logic [23:0] status_q;
  int errors = 0, checks = 0;
  bit done = 0;

  spi_status_responder uut (
    .clk(clk), .rst_n(rst_n), .csb(csb), .op_valid(op_valid), .op_code(op_code),
    .busy_set(busy_set), .sw_wr(sw_wr), .sw_wdata(sw_wdata), .cfg_rd_op(cfg_rd_op),
    .cfg_wren_op(cfg_wren_op), .cfg_wrdi_op(cfg_wrdi_op), .sdo(sdo), .status_q(status_q)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic sw_write(logic [23:0] v);
    sw_wr = 1'b1; sw_wdata = v; tick(); sw_wr = 1'b0;
  endtask

  task automatic commit();
    csb = 1'b0; tick(); csb = 1'b1; tick();
  endtask

  task automatic do_read(logic [7:0] op, output logic [15:0] bits);
    csb = 1'b0; op_valid = 1'b1; op_code = op; tick(); op_valid = 1'b0;
    for (int i = 0; i < 16; i++) begin bits[15-i] = sdo; tick(); end
    csb = 1'b1; tick();
  endtask

  task automatic send_op(logic [7:0] op);
    csb = 1'b0; op_valid = 1'b1; op_code = op; tick(); op_valid = 1'b0; tick();
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] bits;
    logic [23:0] v;
    logic [7:0]  b;
    repeat (3) tick();
    chk("R1 status", 32'(status_q), 0);
    chk("R1 sdo", 32'(sdo), 0);
    rst_n = 1'b1; tick();

    sw_write(24'hC3A55A);
    repeat (3) tick();
    chk("R2 no commit while idle", 32'(status_q), 0);
    commit();
    chk("R2 commit on release", 32'(status_q), 32'hC3A55A);

    for (int i = 0; i < 8; i++) begin
      v = 24'(i * 32'h2B4D91 + 32'h13579B);
      sw_write(v); commit();
      chk("R2 sweep commit", 32'(status_q), 32'(v));
      for (int k = 0; k < 3; k++) begin
        b = v[8*k +: 8];
        do_read(cfg_rd_op[8*k +: 8], bits);
        chk("R3 read byte", 32'(bits), 32'({b, b}));
      end
    end

    sw_write(24'h000000); commit();
    do_read(8'h9F, bits);
    chk("R8 unmatched sdo", 32'(bits), 0);
    chk("R8 unmatched status", 32'(status_q), 0);

    send_op(8'h06);
    chk("R10 wel hidden while selected", 32'(status_q), 0);
    csb = 1'b1; tick();
    chk("R4 wel set", 32'(status_q), 32'h000002);
    send_op(8'h04); csb = 1'b1; tick();
    chk("R5 wel cleared", 32'(status_q), 0);

    busy_set = 1'b1; tick(); busy_set = 1'b0;
    commit();
    chk("R6 busy set", 32'(status_q), 32'h000001);
    sw_write(24'h000000); commit();
    chk("R6 busy cleared by software", 32'(status_q), 0);

    sw_wr = 1'b1; sw_wdata = 24'h123400; busy_set = 1'b1; tick();
    sw_wr = 1'b0; busy_set = 1'b0; commit();
    chk("R7 busy beats software", 32'(status_q), 32'h123401);
    csb = 1'b0; tick();
    sw_wr = 1'b1; sw_wdata = 24'hFFFFFF; op_valid = 1'b1; op_code = 8'h04; tick();
    sw_wr = 1'b0; op_valid = 1'b0; csb = 1'b1; tick();
    chk("R7 wrdi beats software", 32'(status_q), 32'hFFFFFD);

    cfg_wrdi_op = 8'h06; send_op(8'h06); csb = 1'b1; tick();
    chk("R5 wren priority on equal opcodes", 32'(status_q), 32'hFFFFFF);
    cfg_wrdi_op = 8'h04;

    sw_write(24'h00A500); commit();
    op_valid = 1'b1; op_code = 8'h35; tick(); op_valid = 1'b0;
    csb = 1'b0;
    bits = '0;
    for (int i = 0; i < 8; i++) begin tick(); bits[i] = sdo; end
    csb = 1'b1; tick();
    chk("R9 op ignored while deselected", 32'(bits), 0);
    csb = 1'b0; op_valid = 1'b1; op_code = 8'h35; tick(); op_valid = 1'b0;
    tick(); csb = 1'b1; tick();
    chk("R9 sdo quiet after release", 32'(sdo), 0);

    csb = 1'b0; op_valid = 1'b1; op_code = 8'h35; tick(); op_valid = 1'b0;
    bits = '0;
    for (int i = 0; i < 8; i++) begin
      bits[7-i] = sdo;
      if (i == 2) begin sw_wr = 1'b1; sw_wdata = 24'h00FF00; end else sw_wr = 1'b0;
      tick();
    end
    sw_wr = 1'b0;
    chk("R10 read keeps old value", 32'(bits[7:0]), 32'hA5);
    chk("R10 status stable while selected", 32'(status_q), 32'h00A500);
    csb = 1'b1; tick();
    chk("R10 new value after release", 32'(status_q), 32'h00FF00);

    sw_write(24'h3C5A81); commit();
    cfg_rd_op = {8'h05, 8'h05, 8'h05};
    do_read(8'h05, bits);
    chk("R11 lowest index wins", 32'(bits), 32'h8181);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule